// File: doc/BRIEF.md
# Six-Section CIC Interpolator with Selectable Ratio

This block raises the sample rate of one signed 16-bit stream by a factor picked at run time. It uses a six-section cascaded integrator-comb filter. The combs run once per accepted input sample. Each input is then followed by a burst of output strobes, one per clock, and the integrators run on each of those strobes. The first strobe of a burst carries the comb result and the later strobes feed zeros. The filter gain grows with the fifth power of the ratio. A right shift that depends on the ratio brings the result back to 16 bits. A signed fixed-point multiplier can then trim the remaining gain error.

A 3-bit code selects the ratio. Codes that select no ratio put the block in bypass, where each input sample passes straight to the output. Holding `suspend` high clears every filter register, so a stopped stream can restart from a clean state. The ratio code is captured only while the block is in reset or suspended. A code change therefore cannot corrupt a burst that is in progress.

Top module: `cic_interp6`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_valid` is 0 and `out_data` is 0.
- R2: The ratio code maps 1→5, 2→50, 3→500, 6→5000 and 7→50000. Each accepted sample yields exactly that many `out_valid` strobes.
- R3: The output values equal the input sequence, zero-stuffed to the high rate, passed through six cascaded running sums of length R. The result is arithmetically shifted right by the smallest s with 2^s ≥ R^5, which gives 12, 29, 45, 62 and 79 for the five ratios, and its low 16 bits are kept.
- R4: Codes 0, 4 and 5 select bypass. Every `in_valid` sample then appears unchanged on the output two clocks later, before correction.
- R5: A sample presented during a burst is ignored, except in the burst's final strobe cycle. A sample presented in the final strobe cycle is accepted, so inputs spaced exactly R clocks apart give an unbroken output stream.
- R6: While `suspend` is high, all filter state is cleared and `out_valid` and `out_data` stay 0. The first burst after release starts from a zeroed filter.
- R7: `ratio_sel` is captured only while `rst` or `suspend` is high. Changes at other times have no effect.
- R8: When `corr_en` is 1, the filter result y is replaced by (y·`corr_coef` + 2^13) >> 14 using an arithmetic shift. The coefficient is signed, with 1 sign bit, 1 integer bit and 14 fraction bits, so 0x4000 means 1.0. When `corr_en` is 0, y passes unscaled.
- R9: The corrected result saturates to the range −32768 to 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| suspend | input | 1 | Holds all filter state cleared while high |
| ratio_sel | input | 3 | Ratio code, captured during reset or suspend |
| corr_en | input | 1 | Enables the gain-correction multiply |
| corr_coef | input | 16 | Signed 1.1.14 correction coefficient |
| in_data | input | 16 | Signed low-rate input sample |
| in_valid | input | 1 | Input sample strobe |
| out_data | output | 16 | Signed high-rate output sample |
| out_valid | output | 1 | Output sample strobe |

## Verification
Two events can share one clock edge: the final zero-stuffed strobe of one burst, and the acceptance of the next sample, which reloads the comb register and the burst counter. The bench provokes this by streaming inputs exactly R clocks apart. Every output value is compared against an independent running-sum model, so a lost, doubled or misplaced strobe at the burst boundary shows up as a value mismatch or a count mismatch. The bench also sends a second sample in the middle of a burst, which must produce no extra strobes.

// File: rtl/cic_interp_pkg.sv
package cic_interp_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int SECTIONS   = 6;
  localparam int STAGE_GROW = 16;
  localparam int ACC_W      = SAMPLE_W + SECTIONS * STAGE_GROW;
  localparam int CODE_W     = 3;
  localparam int COEF_W     = 16;
  localparam int COEF_FRAC  = 14;
  localparam int RATIO_MAX  = 50000;
  localparam int CNT_W      = $clog2(RATIO_MAX + 1);
  localparam int SH_W       = 7;

  // Upsampling factor per code; 0 means bypass.
  function automatic int unsigned ratio_of(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    return 5;
      3'd2:    return 50;
      3'd3:    return 500;
      3'd6:    return 5000;
      3'd7:    return 50000;
      default: return 0;
    endcase
  endfunction

  // Smallest s with 2^s >= R^5 (filter DC gain brought to at most 1).
  function automatic logic [SH_W-1:0] shift_of(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    return SH_W'(12);
      3'd2:    return SH_W'(29);
      3'd3:    return SH_W'(45);
      3'd6:    return SH_W'(62);
      3'd7:    return SH_W'(79);
      default: return SH_W'(0);
    endcase
  endfunction

  // Arithmetic shift of the wide accumulator, keep the sample-width low part.
  function automatic logic signed [SAMPLE_W-1:0] trim(
    input logic signed [ACC_W-1:0] v, input logic [SH_W-1:0] sh);
    logic signed [ACC_W-1:0] t;
    t = v >>> sh;
    return t[SAMPLE_W-1:0];
  endfunction

  // Multiply by a signed fixed-point coefficient, round half up, saturate.
  function automatic logic signed [SAMPLE_W-1:0] scale_sat(
    input logic signed [SAMPLE_W-1:0] x, input logic signed [COEF_W-1:0] c);
    logic signed [SAMPLE_W+COEF_W:0] p;
    p = (SAMPLE_W+COEF_W+1)'(x) * (SAMPLE_W+COEF_W+1)'(c);
    p = p + ((SAMPLE_W+COEF_W+1)'(1) <<< (COEF_FRAC - 1));
    p = p >>> COEF_FRAC;
    if (p > (SAMPLE_W+COEF_W+1)'((2 ** (SAMPLE_W-1)) - 1))
      return {1'b0, {(SAMPLE_W-1){1'b1}}};
    if (p < -(SAMPLE_W+COEF_W+1)'(2 ** (SAMPLE_W-1)))
      return {1'b1, {(SAMPLE_W-1){1'b0}}};
    return p[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl
  import cic_interp_pkg::*;
#(
  parameter int CW   = CODE_W,
  parameter int CTRW = CNT_W
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [CW-1:0] ratio_sel,
  input  logic          in_valid,
  output logic [CW-1:0] active_code,
  output logic          bypass,
  output logic          accept,
  output logic          strobe,
  output logic          first_strobe
);
  logic [CW-1:0]   code_q;
  logic            busy_q;
  logic            first_q;
  logic [CTRW-1:0] cnt_q;
  logic [CTRW-1:0] ratio;
  logic            last_strobe;

  assign ratio        = CTRW'(ratio_of(code_q));
  assign bypass       = (ratio == '0);
  assign last_strobe  = busy_q && (cnt_q == CTRW'(1));
  assign accept       = in_valid && !bypass && (!busy_q || last_strobe);
  assign strobe       = busy_q;
  assign first_strobe = busy_q && first_q;
  assign active_code  = code_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      code_q  <= ratio_sel;
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      first_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= ratio;
      end else if (last_strobe) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CTRW'(1);
      end
    end
  end

  // R7: code only moves while cleared
  assert_code_frozen_R7: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> $stable(code_q));
  // R2: a burst opens with the full ratio loaded in the counter
  assert_burst_load_R2: assert property (@(posedge clk) disable iff (clr)
    first_q |-> (busy_q && cnt_q == ratio));
  // R5: mid-burst samples never open a burst
  assert_mid_ignored_R5: assert property (@(posedge clk) disable iff (clr)
    (in_valid && busy_q && !last_strobe) |=> !first_q);
  // R2: a burst is not cut short
  assert_burst_hold_R2: assert property (@(posedge clk) disable iff (clr)
    (busy_q && !last_strobe) |=> busy_q);
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain
  import cic_interp_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int AW = ACC_W,
  parameter int NS = SECTIONS
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 accept,
  input  logic signed [DW-1:0] in_data,
  output logic signed [AW-1:0] comb_q
);
  logic signed [AW-1:0] ext;
  assign ext = {{(AW-DW){in_data[DW-1]}}, in_data};

  for (genvar k = 0; k < NS; k++) begin : g_comb
    logic signed [AW-1:0] src;
    logic signed [AW-1:0] dly_q;
    logic signed [AW-1:0] diff;
    if (k == 0) begin : g_head
      assign src = ext;
    end else begin : g_tail
      assign src = g_comb[k-1].diff;
    end
    assign diff = src - dly_q;
    always_ff @(posedge clk) begin
      if (clr)         dly_q <= '0;
      else if (accept) dly_q <= src;
    end
  end

  always_ff @(posedge clk) begin
    if (clr)         comb_q <= '0;
    else if (accept) comb_q <= g_comb[NS-1].diff;
  end

  // R5: comb result moves only on an accepted sample
  assert_comb_hold_R5: assert property (@(posedge clk) disable iff (clr)
    !accept |=> $stable(comb_q));
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain
  import cic_interp_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int AW = ACC_W,
  parameter int NS = SECTIONS,
  parameter int CW = CODE_W
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 strobe,
  input  logic                 first_strobe,
  input  logic                 bypass,
  input  logic [CW-1:0]        code,
  input  logic signed [AW-1:0] comb_q,
  input  logic signed [DW-1:0] in_data,
  input  logic                 in_valid,
  output logic signed [DW-1:0] raw_d,
  output logic                 raw_v
);
  logic signed [AW-1:0] stuffed;
  logic [SH_W-1:0]      sh;

  assign stuffed = first_strobe ? comb_q : '0;
  assign sh      = shift_of(code);

  for (genvar k = 0; k < NS; k++) begin : g_int
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] sum;
    if (k == 0) begin : g_head
      assign sum = acc_q + stuffed;
    end else begin : g_tail
      assign sum = acc_q + g_int[k-1].sum;
    end
    always_ff @(posedge clk) begin
      if (clr)         acc_q <= '0;
      else if (strobe) acc_q <= sum;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      raw_d <= '0;
      raw_v <= 1'b0;
    end else if (bypass) begin
      raw_d <= in_data;
      raw_v <= in_valid;
    end else begin
      raw_d <= strobe ? trim(g_int[NS-1].sum, sh) : raw_d;
      raw_v <= strobe;
    end
  end

  // R4: bypass forwards each sample one clock later
  assert_bypass_follow_R4: assert property (@(posedge clk) disable iff (clr)
    (bypass && in_valid) |=> (raw_v && raw_d == $past(in_data)));
  // R2: no strobe leaves the filter outside a burst
  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (clr)
    (!bypass && !strobe) |=> !raw_v);
endmodule

// File: rtl/cic_gain_corr.sv
module cic_gain_corr
  import cic_interp_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int KW = COEF_W
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [KW-1:0] coef,
  input  logic signed [DW-1:0] in_d,
  input  logic                 in_v,
  output logic signed [DW-1:0] out_d,
  output logic                 out_v
);
  logic signed [DW-1:0] scaled;
  assign scaled = scale_sat(in_d, coef);

  always_ff @(posedge clk) begin
    if (clr) begin
      out_d <= '0;
      out_v <= 1'b0;
    end else begin
      out_v <= in_v;
      if (in_v) out_d <= en ? scaled : in_d;
    end
  end

  // R8: disabled correction is a pure register
  assert_passthru_R8: assert property (@(posedge clk) disable iff (clr)
    (!en && in_v) |=> (out_v && out_d == $past(in_d)));
  // R8: unity coefficient (0x4000) leaves the value unchanged
  assert_unity_R8: assert property (@(posedge clk) disable iff (clr)
    (en && in_v && coef == KW'(16'sh4000)) |=> (out_d == $past(in_d)));
endmodule

// File: rtl/cic_interp6.sv
module cic_interp6
  import cic_interp_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int KW = COEF_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          suspend,
  input  logic [CW-1:0] ratio_sel,
  input  logic          corr_en,
  input  logic [KW-1:0] corr_coef,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  logic                 clr;
  logic [CW-1:0]        active_code;
  logic                 bypass, accept, strobe, first_strobe;
  logic signed [ACC_W-1:0] comb_q;
  logic signed [DW-1:0] raw_d;
  logic                 raw_v;
  logic signed [DW-1:0] out_s;

  assign clr = rst || suspend;

  cic_rate_ctrl #(.CW(CW), .CTRW(CNT_W)) u_ctrl (
    .clk(clk), .clr(clr), .ratio_sel(ratio_sel), .in_valid(in_valid),
    .active_code(active_code), .bypass(bypass), .accept(accept),
    .strobe(strobe), .first_strobe(first_strobe)
  );

  cic_comb_chain #(.DW(DW), .AW(ACC_W), .NS(SECTIONS)) u_comb (
    .clk(clk), .clr(clr), .accept(accept), .in_data(in_data), .comb_q(comb_q)
  );

  cic_integ_chain #(.DW(DW), .AW(ACC_W), .NS(SECTIONS), .CW(CW)) u_integ (
    .clk(clk), .clr(clr), .strobe(strobe), .first_strobe(first_strobe),
    .bypass(bypass), .code(active_code), .comb_q(comb_q),
    .in_data(in_data), .in_valid(in_valid), .raw_d(raw_d), .raw_v(raw_v)
  );

  cic_gain_corr #(.DW(DW), .KW(KW)) u_corr (
    .clk(clk), .clr(clr), .en(corr_en), .coef(corr_coef),
    .in_d(raw_d), .in_v(raw_v), .out_d(out_s), .out_v(out_valid)
  );

  assign out_data = out_s;

  // R1: reset leaves the output quiet
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
  // R6: suspend clears the output stage
  assert_suspend_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    suspend |=> (!out_valid && out_data == '0));
endmodule

// File: tb/cic_interp6_tb_top.sv
module cic_interp6_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        suspend = 1'b0;
  logic [2:0]  ratio_sel = 3'd1;
  logic        corr_en = 1'b0;
  logic [15:0] corr_coef = 16'h4000;
  logic [15:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic [15:0] out_data;
  logic        out_valid;

  always #10 clk = ~clk;

  cic_interp6 dut_i (
    .clk(clk), .rst(rst), .suspend(suspend), .ratio_sel(ratio_sel),
    .corr_en(corr_en), .corr_coef(corr_coef), .in_data(in_data),
    .in_valid(in_valid), .out_data(out_data), .out_valid(out_valid)
  );

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  string tag_q[$];

  // independent model: six running sums of length R at the high rate
  logic signed [127:0] mbuf [6][64];
  logic signed [127:0] msum [6];
  int mr = 5, ms = 12, midx = 0;
  bit mbyp = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 6; k++) begin
      msum[k] = '0;
      for (int j = 0; j < 64; j++) mbuf[k][j] = '0;
    end
    midx = 0;
  endtask

  task automatic set_mode(input int code);
    logic [127:0] p5;
    case (code)
      1: mr = 5;
      2: mr = 50;
      3: mr = 500;
      6: mr = 5000;
      7: mr = 50000;
      default: mr = 0;
    endcase
    mbyp = (mr == 0);
    ms = 0;
    if (!mbyp) begin
      p5 = 128'(mr) * 128'(mr) * 128'(mr) * 128'(mr) * 128'(mr);
      while ((128'd1 << ms) < p5) ms++;
    end
  endtask

  function automatic int corr(input int v);
    int p, r;
    if (!corr_en) return v;
    p = v * int'($signed(corr_coef));
    r = (p + 8192) >>> 14;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic push_sample(input int x, input string tag);
    logic signed [127:0] v, old, sh;
    if (mbyp) begin
      exp_q.push_back(corr(x));
      tag_q.push_back(tag);
      return;
    end
    for (int j = 0; j < mr; j++) begin
      v = (j == 0) ? 128'(signed'(x)) : '0;
      for (int k = 0; k < 6; k++) begin
        old = mbuf[k][midx];
        mbuf[k][midx] = v;
        msum[k] = msum[k] + v - old;
        v = msum[k];
      end
      midx = (midx + 1) % mr;
      sh = v >>> ms;
      exp_q.push_back(corr(int'($signed(sh[15:0]))));
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(input int x, input string tag);
    @(negedge clk);
    in_data  = x[15:0];
    in_valid = 1'b1;
    push_sample(x, tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic poke(input int x);
    @(negedge clk);
    in_data  = x[15:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    gap(mbyp ? 10 : mr + 10);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic do_suspend(input int code);
    @(negedge clk);
    suspend   = 1'b1;
    ratio_sel = 3'(code);
    @(posedge clk);
    #1;
    exp_q.delete();
    tag_q.delete();
    model_clear();
    set_mode(code);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!out_valid && out_data == 16'h0, "R6 quiet", int'(out_valid), 0);
    end
    @(negedge clk);
    suspend = 1'b0;
  endtask

  // monitor: pop and compare every produced sample
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected strobe", int'($signed(out_data)), 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'($signed(out_data)) == e, t, int'($signed(out_data)), e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_clear();
    set_mode(1);
    repeat (4) @(negedge clk);
    check(!out_valid && out_data == 16'h0, "R1 reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && out_data == 16'h0, "R1 after reset", int'(out_data), 0);

    // R3/R5: streaming at exactly R spacing, accept on the last strobe
    send(1000, "R3 stream");   gap(mr - 2);
    send(-2000, "R3 stream");  gap(mr - 2);
    send(32767, "R5 boundary"); gap(mr - 2);
    send(-32768, "R5 boundary"); gap(mr - 2);
    send(12345, "R3 stream");
    drained("R2 count r5");

    // R5: sample in mid-burst is dropped
    send(500, "R5 first");
    poke(9999);
    gap(mr);
    send(-700, "R5 after drop");
    drained("R5 no extra");

    // R7: code change while running has no effect
    @(negedge clk);
    ratio_sel = 3'd2;
    send(3000, "R7 old ratio"); gap(mr + 3);
    send(-3000, "R7 old ratio");
    drained("R7 count");

    // R6: suspend mid-burst, then new ratio 50 with correction
    send(20000, "R6 cut");
    gap(2);
    do_suspend(2);
    @(negedge clk);
    corr_en   = 1'b1;
    corr_coef = 16'h5000;
    send(8000, "R8 scaled R3");  gap(mr - 2);
    send(-16000, "R8 scaled R3"); gap(mr - 2);
    send(30000, "R8 scaled R3");
    drained("R2 count r50");

    // R4/R9: bypass with saturation
    do_suspend(0);
    @(negedge clk);
    corr_coef = 16'h7FFF;
    send(30000, "R9 high");
    send(-30000, "R9 low");
    send(1000, "R8 round");
    gap(4);
    corr_en = 1'b0;
    send(1234, "R4 pass");
    drained("R4 count");
    do_suspend(5);
    send(-77, "R4 code5");
    drained("R4 code5 count");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule